// File: doc/BRIEF.md
# Store Gathering Pipe

This block sits on the processor's store path in front of the memory bus. Software programs one line-aligned physical target address and an enable bit. While gathering is on, every store aimed exactly at that target is packed into a 128-byte circular byte buffer. The bytes go in back to back, most significant byte first, whatever the store size. Each time a full 32-byte line has built up, the block sends that line on a burst port as four 64-bit beats with a valid/ready handshake, addressed to the target line.

Any store that does not match is forwarded unchanged on a separate pass-through port. Matching needs the enable set, the upper address bits equal to the target line, and the low five address bits all zero. Reprogramming the target throws away whatever is buffered. No flush command exists: a partial line leaves the buffer only once later stores complete it. When the buffer lacks room for an incoming matching store, the store input is held off until a burst beat frees space.

Top module: `gather_pipe`

## Requirements
- R1: A store is gathered only when the enable is set, st_addr[31:5] equals the target's bits [31:5], and st_addr[4:0] is zero. A gathered store never shows pt_valid.
- R2: st_size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The value sits in the low 8*n bits of st_data. Its most significant byte is buffered first, and successive stores follow on with no gaps.
- R3: Once 32 or more bytes are buffered, bst_valid rises. The line leaves as four beats: the earliest byte is in bst_data[63:56] of the first beat, bst_last is high on the fourth beat only, and bst_addr is the target with bits [4:0] zero.
- R4: While bst_valid is high and bst_ready is low, bst_valid, bst_data and bst_addr hold steady (unless the target is rewritten).
- R5: A non-matching store is presented on pt_valid/pt_addr/pt_size/pt_data in the same cycle with its fields unchanged, and st_ready follows pt_ready.
- R6: A matching store of n bytes is accepted only when at least n of the 128 bytes are free; otherwise st_ready stays low.
- R7: A target write empties the buffer: not_empty is low in the next cycle and a burst already in progress is dropped.
- R8: not_empty is high exactly while at least one byte is buffered.
- R9: Fewer than 32 buffered bytes never raise bst_valid. Clearing the enable keeps buffered bytes, and they are sent once later matching stores complete the line.
- R10: In a cycle with any configuration write, st_ready and pt_valid are low. The new setting governs stores from the next cycle.
- R11: After reset, the enable is clear, the target is zero and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en_we | input | 1 | Write strobe for the enable bit |
| cfg_en_val | input | 1 | New enable value |
| cfg_addr_we | input | 1 | Write strobe for the target address; discards buffered data |
| cfg_addr_val | input | 32 | New target address (bits [4:0] ignored) |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| st_addr | input | 32 | Store physical address |
| st_size | input | 2 | Store size code (0:1, 1:2, 2:4, 3:8 bytes) |
| st_data | input | 64 | Store value, right-aligned |
| pt_valid | output | 1 | Pass-through store valid |
| pt_ready | input | 1 | Pass-through consumer ready |
| pt_addr | output | 32 | Pass-through store address |
| pt_size | output | 2 | Pass-through store size code |
| pt_data | output | 64 | Pass-through store data |
| not_empty | output | 1 | Buffer holds at least one byte |
| bst_valid | output | 1 | Burst beat valid |
| bst_ready | input | 1 | Burst consumer ready |
| bst_addr | output | 32 | Line address of the burst |
| bst_data | output | 64 | Beat data, earliest byte in bits [63:56] |
| bst_last | output | 1 | Final beat of the line |

## Verification
On every cycle the assertions check the following: the byte count never overflows or underflows, a pending beat and its address and data hold still while stalled, gathered stores occur only with the enable set, a burst can only begin from a full line, and a target write leaves the buffer empty. The directed scenarios are needed for everything about data content. That covers big-endian packing across mixed sizes, a store that straddles the circular wrap point, the exact match rule on the offset and upper bits, retention of residual bytes across a disable, the stall at a nearly full buffer, and the loss of a half-sent line on discard.

// File: rtl/wgp_pkg.sv
package wgp_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } wgp_size_e;

    function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/wgp_cfg_match.sv
module wgp_cfg_match #(
    parameter int ADDR_W  = 32,
    parameter int LINE_LG = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_en_we,
    input  logic                      cfg_en_val,
    input  logic                      cfg_addr_we,
    input  logic [ADDR_W-1:0]         cfg_addr_val,
    input  logic [ADDR_W-1:0]         st_addr,
    output logic                      en,
    output logic [ADDR_W-LINE_LG-1:0] tag,
    output logic                      hit
);
    localparam int TAG_W = ADDR_W - LINE_LG;

    typedef struct packed {
        logic             en;
        logic [TAG_W-1:0] tag;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_en_we)   cfg_d.en  = cfg_en_val;
        if (cfg_addr_we) cfg_d.tag = cfg_addr_val[ADDR_W-1:LINE_LG];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en  = cfg_q.en;
    assign tag = cfg_q.tag;
    assign hit = cfg_q.en
              && (st_addr[ADDR_W-1:LINE_LG] == cfg_q.tag)
              && (st_addr[LINE_LG-1:0] == '0);

    // R10: a target write shows up in the register on the next cycle
    a_r10_tag_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |=> (tag == $past(cfg_addr_val[ADDR_W-1:LINE_LG])));

endmodule

// File: rtl/wgp_byte_fifo.sv
module wgp_byte_fifo #(
    parameter int DEPTH = 128,
    parameter int BEAT  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic [$clog2(BEAT):0]          push_n,
    input  logic [BEAT-1:0][7:0]           push_bytes,
    input  logic                           pop,
    output logic [8*BEAT-1:0]              beat_data,
    output logic [$clog2(DEPTH):0]         count,
    output logic [$clog2(DEPTH):0]         free
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      wr;
        logic [PTR_W-1:0]      rd;
        logic [CNT_W-1:0]      cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;

    always_comb begin
        logic [PTR_W-1:0] slot;
        fifo_d = fifo_q;
        slot   = '0;
        if (clear) begin
            fifo_d.wr  = '0;
            fifo_d.rd  = '0;
            fifo_d.cnt = '0;
        end else begin
            if (push) begin
                for (int i = 0; i < BEAT; i++) begin
                    if (i < int'(push_n)) begin
                        slot = fifo_q.wr + PTR_W'(i);
                        fifo_d.mem[slot] = push_bytes[i];
                    end
                end
                fifo_d.wr = fifo_q.wr + PTR_W'(push_n);
            end
            if (pop) fifo_d.rd = fifo_q.rd + PTR_W'(BEAT);
            fifo_d.cnt = fifo_q.cnt
                       + (push ? CNT_W'(push_n) : CNT_W'(0))
                       - (pop  ? CNT_W'(BEAT)   : CNT_W'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_comb begin
        logic [PTR_W-1:0] rslot;
        beat_data = '0;
        rslot     = '0;
        for (int i = 0; i < BEAT; i++) begin
            rslot = fifo_q.rd + PTR_W'(i);
            beat_data[(BEAT-1-i)*8 +: 8] = fifo_q.mem[rslot];
        end
    end

    assign count = fifo_q.cnt;
    assign free  = CNT_W'(DEPTH) - fifo_q.cnt;

    // R6: a push never overfills the buffer
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |-> ((fifo_q.cnt + CNT_W'(push_n)) <= CNT_W'(DEPTH)));

    // R3: a beat is only taken from bytes already present
    a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clear) |-> (fifo_q.cnt >= CNT_W'(BEAT)));

endmodule

// File: rtl/wgp_burst_ctl.sv
module wgp_burst_ctl #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic line_ready,
    input  logic bst_ready,
    output logic bst_valid,
    output logic bst_last,
    output logic pop
);
    localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;

    typedef struct packed {
        logic [BW-1:0] beat;
    } bctl_t;

    bctl_t bctl_d, bctl_q;

    assign bst_valid = (bctl_q.beat != '0) || line_ready;
    assign bst_last  = (bctl_q.beat == BW'(BEATS-1));
    assign pop       = bst_valid && bst_ready && !clear;

    always_comb begin
        bctl_d = bctl_q;
        if (clear)         bctl_d.beat = '0;
        else if (pop)      bctl_d.beat = bst_last ? '0 : bctl_q.beat + BW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bctl_q <= '0;
        else        bctl_q <= bctl_d;
    end

    // R4: a stalled beat stays offered
    a_r4_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready && !clear) |=> bst_valid);

    // R3: after the final beat the next line starts from the first beat
    a_r3_last_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && bst_last) |=> !bst_last || (BEATS == 1));

endmodule

// File: rtl/gather_pipe.sv
module gather_pipe #(
    parameter int ADDR_W     = 32,
    parameter int FIFO_BYTES = 128,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_en_we,
    input  logic                    cfg_en_val,
    input  logic                    cfg_addr_we,
    input  logic [ADDR_W-1:0]       cfg_addr_val,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [1:0]              st_size,
    input  logic [8*BEAT_BYTES-1:0] st_data,
    output logic                    pt_valid,
    input  logic                    pt_ready,
    output logic [ADDR_W-1:0]       pt_addr,
    output logic [1:0]              pt_size,
    output logic [8*BEAT_BYTES-1:0] pt_data,
    output logic                    not_empty,
    output logic                    bst_valid,
    input  logic                    bst_ready,
    output logic [ADDR_W-1:0]       bst_addr,
    output logic [8*BEAT_BYTES-1:0] bst_data,
    output logic                    bst_last
);
    import wgp_pkg::*;

    localparam int DW      = 8 * BEAT_BYTES;
    localparam int LINE_LG = $clog2(LINE_BYTES);
    localparam int BEATS   = LINE_BYTES / BEAT_BYTES;
    localparam int NB_W    = $clog2(BEAT_BYTES) + 1;
    localparam int CNT_W   = $clog2(FIFO_BYTES) + 1;

    logic                      en, hit, cfg_busy, space_ok, push, pop, line_ready;
    logic [ADDR_W-LINE_LG-1:0] tag;
    logic [NB_W-1:0]           n_bytes;
    logic [DW-1:0]             aligned;
    logic [BEAT_BYTES-1:0][7:0] push_bytes;
    logic [CNT_W-1:0]          count, free;

    wgp_cfg_match #(.ADDR_W(ADDR_W), .LINE_LG(LINE_LG)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_val(cfg_addr_val),
        .st_addr(st_addr), .en(en), .tag(tag), .hit(hit)
    );

    // Store decode: size to byte count, value shifted so its top byte leads
    always_comb begin
        n_bytes  = NB_W'(size_to_bytes(st_size));
        aligned  = st_data << (8 * (BEAT_BYTES - int'(n_bytes)));
        for (int i = 0; i < BEAT_BYTES; i++) begin
            push_bytes[i] = aligned[DW-1-8*i -: 8];
        end
        cfg_busy = cfg_en_we || cfg_addr_we;
        space_ok = free >= CNT_W'(n_bytes);
        st_ready = !cfg_busy && (hit ? space_ok : pt_ready);
        push     = st_valid && st_ready && hit;
        pt_valid = st_valid && !hit && !cfg_busy;
    end

    assign pt_addr = st_addr;
    assign pt_size = st_size;
    assign pt_data = st_data;

    wgp_byte_fifo #(.DEPTH(FIFO_BYTES), .BEAT(BEAT_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(cfg_addr_we),
        .push(push), .push_n(n_bytes), .push_bytes(push_bytes),
        .pop(pop), .beat_data(bst_data), .count(count), .free(free)
    );

    assign line_ready = count >= CNT_W'(LINE_BYTES);

    wgp_burst_ctl #(.BEATS(BEATS)) u_burst (
        .clk(clk), .rst_n(rst_n), .clear(cfg_addr_we),
        .line_ready(line_ready), .bst_ready(bst_ready),
        .bst_valid(bst_valid), .bst_last(bst_last), .pop(pop)
    );

    assign bst_addr  = {tag, LINE_LG'(0)};
    assign not_empty = count != '0;

    // R7: a target write leaves nothing buffered
    a_r7_discard_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_we |=> !not_empty);

    // R4: a stalled beat keeps its payload and address
    a_r4_beat_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_valid && !bst_ready && !cfg_addr_we) |=> ($stable(bst_data) && $stable(bst_addr)));

    // R1: bytes enter the buffer only while gathering is enabled
    a_r1_push_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> en);

    // R9: a burst can only start from a complete line
    a_r9_full_line_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bst_valid) |-> (count >= CNT_W'(LINE_BYTES)));

    // R5: a store never goes both ways
    a_r5_single_route: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> !push);

endmodule

// File: tb/tb_gather_pipe.sv
module tb_gather_pipe;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_en_we, cfg_en_val, cfg_addr_we;
    logic [31:0] cfg_addr_val;
    logic        st_valid, st_ready;
    logic [31:0] st_addr;
    logic [1:0]  st_size;
    logic [63:0] st_data;
    logic        pt_valid, pt_ready;
    logic [31:0] pt_addr;
    logic [1:0]  pt_size;
    logic [63:0] pt_data;
    logic        not_empty, bst_valid, bst_ready, bst_last;
    logic [31:0] bst_addr;
    logic [63:0] bst_data;

    always #10 clk = ~clk;

    gather_pipe dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_en_we(cfg_en_we), .cfg_en_val(cfg_en_val),
        .cfg_addr_we(cfg_addr_we), .cfg_addr_val(cfg_addr_val),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_size(st_size), .st_data(st_data),
        .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_addr(pt_addr),
        .pt_size(pt_size), .pt_data(pt_data),
        .not_empty(not_empty), .bst_valid(bst_valid), .bst_ready(bst_ready),
        .bst_addr(bst_addr), .bst_data(bst_data), .bst_last(bst_last)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0]  exp_q[$];
    logic [31:0] tgt = 32'h0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic set_target(input logic [31:0] a);
        @(negedge clk);
        cfg_addr_we = 1'b1; cfg_addr_val = a;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        tgt = a;
        exp_q.delete();
    endtask

    task automatic set_enable(input bit v);
        @(negedge clk);
        cfg_en_we = 1'b1; cfg_en_val = v;
        @(negedge clk);
        cfg_en_we = 1'b0;
    endtask

    task automatic put(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] dat, input bit hit);
        int n;
        n = 1 << sz;
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_size = sz; st_data = dat;
        #1;
        while (!st_ready) begin @(negedge clk); #1; end
        if (hit) chk(!pt_valid, "R1 gathered store on pass-through", {63'd0, pt_valid}, 64'd0);
        else     chk(pt_valid && pt_addr == a && pt_size == sz && pt_data == dat,
                     "R5 pass-through fields", pt_data, dat);
        @(negedge clk);
        st_valid = 1'b0;
        if (hit) for (int i = 0; i < n; i++) exp_q.push_back(dat[(n-1-i)*8 +: 8]);
    endtask

    task automatic put_bytes(input int cnt, input logic [7:0] seed);
        for (int i = 0; i < cnt; i++) put(tgt, 2'd0, {56'd0, seed + 8'(i)}, 1'b1);
    endtask

    task automatic collect(input string req);
        logic [63:0] e;
        bst_ready = 1'b1;
        for (int b = 0; b < 4; b++) begin
            #1;
            while (!bst_valid) begin @(negedge clk); #1; end
            e = '0;
            for (int i = 0; i < 8; i++) e = {e[55:0], (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx};
            chk(bst_data === e, req, bst_data, e);
            chk(bst_last == (b == 3), "R3 last flag", {63'd0, bst_last}, {63'd0, b == 3});
            chk(bst_addr == {tgt[31:5], 5'd0}, "R3 burst address", {32'd0, bst_addr}, {32'd0, tgt[31:5], 5'd0});
            @(negedge clk);
        end
        bst_ready = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk(!not_empty, "R11 empty after reset", {63'd0, not_empty}, 64'd0);
        chk(!bst_valid, "R11 no burst after reset", {63'd0, bst_valid}, 64'd0);
        put(32'h0, 2'd0, 64'h5A, 1'b0);
        chk(!not_empty, "R11 disabled at reset, store bypassed", {63'd0, not_empty}, 64'd0);
    endtask

    task automatic t_packing;
        set_target(32'h0C00_8000);
        set_enable(1'b1);
        put(tgt, 2'd0, 64'hAA, 1'b1);
        put(tgt, 2'd1, 64'hAABB, 1'b1);
        put(tgt, 2'd2, 64'h1122_3344, 1'b1);
        put(tgt, 2'd3, 64'h3F80_0000_3FF0_0000, 1'b1);
        put(tgt, 2'd3, 64'h0102_0304_0506_0708, 1'b1);
        put(tgt, 2'd3, 64'h1112_1314_1516_1718, 1'b1);
        #1;
        chk(!bst_valid, "R9 31 bytes give no burst", {63'd0, bst_valid}, 64'd0);
        chk(not_empty, "R8 not_empty with data", {63'd0, not_empty}, 64'd1);
        put(tgt, 2'd0, 64'hEE, 1'b1);
        #1;
        chk(bst_data == 64'hAAAA_BB11_2233_443F, "R2 big-endian packing", bst_data, 64'hAAAA_BB11_2233_443F);
        collect("R3 burst data after packing");
        #1;
        chk(!not_empty, "R8 empty after full drain", {63'd0, not_empty}, 64'd0);
    endtask

    task automatic t_match;
        put(tgt + 32'd1, 2'd0, 64'h11, 1'b0);
        put(tgt + 32'd4, 2'd2, 64'hCAFE_F00D, 1'b0);
        put(tgt ^ 32'h20, 2'd3, 64'h1234_5678_9ABC_DEF0, 1'b0);
        put(tgt ^ 32'h8000_0000, 2'd1, 64'hBEEF, 1'b0);
        #1;
        chk(!not_empty, "R1 mismatched stores not buffered", {63'd0, not_empty}, 64'd0);
    endtask

    task automatic t_bypass_stall;
        @(negedge clk);
        pt_ready = 1'b0;
        st_valid = 1'b1; st_addr = tgt + 32'd8; st_size = 2'd2; st_data = 64'h0A0B_0C0D;
        #1;
        chk(pt_valid && !st_ready, "R5 stall follows pt_ready", {62'd0, pt_valid, st_ready}, 64'd2);
        @(negedge clk);
        pt_ready = 1'b1;
        #1;
        chk(st_ready && pt_data == 64'h0A0B_0C0D, "R5 release follows pt_ready", pt_data, 64'h0A0B_0C0D);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_disable_keeps;
        put_bytes(5, 8'h40);
        set_enable(1'b0);
        put(tgt, 2'd0, 64'h99, 1'b0);
        #1;
        chk(not_empty, "R9 residual kept while disabled", {63'd0, not_empty}, 64'd1);
        set_enable(1'b1);
        put_bytes(3, 8'h50);
        put(tgt, 2'd3, 64'h6061_6263_6465_6667, 1'b1);
        put(tgt, 2'd3, 64'h7071_7273_7475_7677, 1'b1);
        put(tgt, 2'd3, 64'h8081_8283_8485_8687, 1'b1);
        collect("R9 residual completed by later stores");
    endtask

    task automatic t_discard;
        put(tgt, 2'd3, 64'hDEAD_BEEF_0000_1111, 1'b1);
        put(tgt, 2'd2, 64'h2222_3333, 1'b1);
        set_target(32'h0000_1A40);
        #1;
        chk(!not_empty, "R7 target write empties", {63'd0, not_empty}, 64'd0);
        for (int i = 0; i < 4; i++) put(tgt, 2'd3, {8'(i), 56'h00_1122_3344_5566}, 1'b1);
        collect("R7 only post-discard data sent");
        for (int i = 0; i < 4; i++) put(tgt, 2'd3, {8'(i+8), 56'h77_6655_4433_2211}, 1'b1);
        bst_ready = 1'b1;
        @(negedge clk);
        bst_ready = 1'b0;
        set_target(32'h0000_1A40);
        #1;
        chk(!bst_valid && !not_empty, "R7 partial burst dropped", {62'd0, bst_valid, not_empty}, 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] snap;
        for (int i = 0; i < 4; i++) put(tgt, 2'd3, {32'h5555_0000 + 32'(i), 32'hA5A5_A5A5}, 1'b1);
        #1;
        snap = bst_data;
        repeat (3) @(negedge clk);
        #1;
        chk(bst_valid && bst_data == snap, "R4 beat held under stall", bst_data, snap);
        collect("R4 data after stall");
    endtask

    task automatic t_full_wrap;
        put(tgt, 2'd0, 64'h01, 1'b1);
        for (int i = 0; i < 15; i++) put(tgt, 2'd3, {8'(i), 8'hC0, 48'h0102_0304_0506}, 1'b1);
        @(negedge clk);
        st_valid = 1'b1; st_addr = tgt; st_size = 2'd3; st_data = 64'hF0F1_F2F3_F4F5_F6F7;
        repeat (3) begin
            #1;
            chk(!st_ready, "R6 stall with 7 bytes free", {63'd0, st_ready}, 64'd0);
            @(negedge clk);
        end
        st_valid = 1'b0;
        collect("R6 burst after stall");
        put(tgt, 2'd3, 64'hF0F1_F2F3_F4F5_F6F7, 1'b1);
        collect("R2 wrapped store line 1");
        collect("R2 wrapped store line 2");
        collect("R2 wrapped store line 3");
        #1;
        chk(not_empty && !bst_valid, "R9 single residual byte", {62'd0, not_empty, bst_valid}, 64'd2);
        set_target(tgt);
    endtask

    task automatic t_cfg_priority;
        @(negedge clk);
        cfg_en_we = 1'b1; cfg_en_val = 1'b1;
        st_valid = 1'b1; st_addr = tgt; st_size = 2'd0; st_data = 64'h77;
        #1;
        chk(!st_ready && !pt_valid, "R10 store held during config write", {62'd0, st_ready, pt_valid}, 64'd0);
        @(negedge clk);
        cfg_en_we = 1'b0;
        #1;
        chk(st_ready, "R10 store accepted after config write", {63'd0, st_ready}, 64'd1);
        @(negedge clk);
        st_valid = 1'b0;
        #1;
        chk(not_empty, "R10 store gathered next cycle", {63'd0, not_empty}, 64'd1);
        set_target(tgt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_en_we = 1'b0; cfg_en_val = 1'b0; cfg_addr_we = 1'b0; cfg_addr_val = '0;
        st_valid = 1'b0; st_addr = '0; st_size = '0; st_data = '0;
        pt_ready = 1'b1; bst_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_packing();
        t_match();
        t_bypass_stall();
        t_disable_keeps();
        t_discard();
        t_hold();
        t_full_wrap();
        t_cfg_priority();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule